// File: doc/BRIEF.md
# Serial Affine Vector Generator

This block produces the linear-term vector of a bound-constrained quadratic program once per solve. It holds a coefficient matrix of `ROWS` rows by `VLEN` (eleven) columns and an eleven-element parameter vector. The parameter vector holds five plant states, five reference values and a trailing constant of one. After `start`, the block forms one output element per matrix row. Each element is the dot product of that row with the parameter vector. A single multiply-accumulate unit builds it serially, over eleven consecutive cycles.

The 32-bit by 25-bit product is built from two narrower multiplies. The parameter word is cut into an unsigned low half and a signed high half. The two partial products are registered, then shifted and added in the next stage. The accumulated sum is rescaled to the solver's 41-bit format with 22 fraction bits, rounding toward minus infinity and wrapping on overflow. It is then sent downstream as a write on the forwarded load bus.

The block sits in front of the solver on the load path. While idle, it forwards host load traffic one cycle late with the data zero-extended to 41 bits, and it captures writes addressed to its own two memories. While busy, it drives the forwarded bus with its own results and ignores the host. After the last result has been written, it pulses `solver_go` to start the solver. Its controller has three states:

- **IDLE**: moves to **RUN** on `start`.
- **RUN**: moves to **DRAIN** once the last matrix element has been issued.
- **DRAIN**: moves back to **IDLE** in the same cycle that `solver_go` is raised.

Top module: `affine_vec_gen`

## Requirements
- R1: While `rst` is high and just after it, `busy`, `fwd_wr`, `solver_go`, `fwd_sel` and `fwd_data` are all zero.
- R2: In IDLE, one cycle after the host drives them, `fwd_sel` equals `host_sel`, `fwd_wr` equals `host_wr` and `fwd_data` equals `host_data` zero-extended to 41 bits.
- R3: In IDLE, a host write with `host_sel` = 4'd1 stores `host_data[24:0]` (signed, 20 fraction bits) as the next matrix entry in row-major order. The entry counter returns to zero whenever `host_sel` is not 4'd1.
- R4: In IDLE, a host write with `host_sel` = 4'd2 stores `host_data[31:0]` (signed, 20 fraction bits) as the next vector element. Its counter returns to zero whenever `host_sel` is not 4'd2.
- R5: The result for row i is floor(sum over j of M[i][j]*v[j] / 2^18), taken as the low 41 bits of two's complement.
- R6: While busy, `fwd_wr` is high exactly `ROWS` times, with `fwd_sel` = 4'd3. The results come in ascending row order: row i is written in the cycle that follows the clock edge 11*i+15 edges after the edge that accepted `start`.
- R7: `solver_go` is a single-cycle pulse, raised by the clock edge exactly 11*`ROWS`+9 edges after the edge that accepted `start`. `busy` falls on that same edge.
- R8: A `start` received while busy has no effect on the timing or values of the current computation.
- R9: Host writes received while busy are neither stored nor forwarded.
- R10: Results are exact for operands at the extremes of both signed ranges, including the case where the sum wraps in the 41-bit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 4 | Load target selector from the host |
| host_data | input | 32 | Load data from the host |
| host_wr | input | 1 | Host write strobe |
| start | input | 1 | Begins a computation when idle |
| fwd_sel | output | 4 | Load target selector toward the solver |
| fwd_data | output | 41 | Load data toward the solver |
| fwd_wr | output | 1 | Write strobe toward the solver |
| solver_go | output | 1 | One-cycle pulse that starts the solver |
| busy | output | 1 | High from the cycle after `start` is accepted until the trigger |

## Verification
Several properties are checked on every cycle, with checker counters:

- the split multiplier matches a full-width product of its inputs from two cycles earlier;
- the accumulator holds between elements;
- the trigger is a single-cycle pulse that arrives with `busy` low, at exactly 11*`ROWS`+9 cycles;
- exactly `ROWS` result writes occur per run, all under selector 3;
- idle traffic is forwarded unchanged.

Only the bench scenarios can show the rest:

- the arithmetic value of each row, including floor rounding, wrap and extreme operands;
- the row-major fill order and the counter restarts of both memories;
- that host writes and a repeated `start` during a run leave both the current results and a later run unchanged.

// File: rtl/avg_pkg.sv
package avg_pkg;

    // Selector codes on the load bus
    localparam logic [3:0] SEL_MAT  = 4'd1;  // coefficient matrix, row-major
    localparam logic [3:0] SEL_VEC  = 4'd2;  // parameter vector
    localparam logic [3:0] SEL_FVEC = 4'd3;  // solver linear-term memory

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN
    } gen_state_e;

    // Tag that travels alongside each product through the pipeline
    typedef struct packed {
        logic vld;   // a real element is present
        logic head;  // first column of a row
        logic endr;  // last column of a row
        logic endv;  // last column of the last row
    } tag_t;

endpackage

// File: rtl/avg_store.sv
module avg_store
    import avg_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int VLEN = 11,
    parameter int XW   = 32,
    parameter int FW   = 25,
    parameter int RW   = 3,
    parameter int CW   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 idle,
    input  logic [3:0]           host_sel,
    input  logic [XW-1:0]        host_data,
    input  logic                 host_wr,
    input  logic [RW-1:0]        rd_row,
    input  logic [CW-1:0]        rd_col,
    output logic signed [FW-1:0] f_op,
    output logic signed [XW-1:0] x_op
);

    localparam int FN  = ROWS * VLEN;
    localparam int MAW = (FN > 1) ? $clog2(FN) : 1;

    logic signed [FW-1:0] fmem [FN];
    logic signed [XW-1:0] xmem [VLEN];

    logic [MAW-1:0] mat_cnt;
    logic [CW-1:0]  vec_cnt;
    logic [MAW-1:0] rd_idx;
    logic           mat_we;
    logic           vec_we;

    assign mat_we = idle && host_wr && (host_sel == SEL_MAT);
    assign vec_we = idle && host_wr && (host_sel == SEL_VEC);
    assign rd_idx = MAW'(rd_row) * MAW'(VLEN) + MAW'(rd_col);

    // Fill counters restart whenever the host selects another target
    always_ff @(posedge clk) begin
        if (rst || host_sel != SEL_MAT) begin
            mat_cnt <= '0;
        end else if (mat_we) begin
            mat_cnt <= (mat_cnt == MAW'(FN - 1)) ? '0 : mat_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || host_sel != SEL_VEC) begin
            vec_cnt <= '0;
        end else if (vec_we) begin
            vec_cnt <= (vec_cnt == CW'(VLEN - 1)) ? '0 : vec_cnt + 1'b1;
        end
    end

    // Storage and registered operand read
    always_ff @(posedge clk) begin
        if (mat_we) begin
            fmem[mat_cnt] <= host_data[FW-1:0];
        end
        if (vec_we) begin
            xmem[vec_cnt] <= host_data;
        end
        f_op <= fmem[rd_idx];
        x_op <= xmem[rd_col];
    end

    p_cnt_range_r3_r4: assert property (@(posedge clk) disable iff (rst)
        (int'(mat_cnt) < FN) && (int'(vec_cnt) < VLEN));

endmodule

// File: rtl/avg_splitmul.sv
module avg_splitmul #(
    parameter int AW = 32,  // wide operand (split)
    parameter int BW = 25,  // narrow operand
    parameter int LO = 16   // width of the unsigned low part
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [AW-1:0]    a,
    input  logic signed [BW-1:0]    b,
    output logic signed [AW+BW-1:0] p
);

    localparam int HW  = AW - LO;
    localparam int PW  = AW + BW;
    localparam int PLW = BW + LO + 1;
    localparam int PHW = BW + HW;

    logic signed [PLW-1:0] lo_a, lo_b, lo_q;
    logic signed [PHW-1:0] hi_a, hi_b, hi_q;

    // Low half as a non-negative signed value, high half keeps the sign
    assign lo_a = PLW'($signed({1'b0, a[LO-1:0]}));
    assign lo_b = PLW'(b);
    assign hi_a = PHW'($signed(a[AW-1:LO]));
    assign hi_b = PHW'(b);

    // Stage 1: partial products
    always_ff @(posedge clk) begin
        lo_q <= lo_a * lo_b;
        hi_q <= hi_a * hi_b;
    end

    // Stage 2: long-multiplication combine
    always_ff @(posedge clk) begin
        p <= (PW'(hi_q) <<< LO) + PW'(lo_q);
    end

    // Checker: full-width reference two cycles back
    logic signed [PW-1:0] a_x, b_x;
    logic [1:0]           warm;

    assign a_x = PW'(a);
    assign b_x = PW'(b);

    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= '0;
        end else if (warm != 2'd3) begin
            warm <= warm + 1'b1;
        end
    end

    p_split_exact_r10: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (p == $past(a_x, 2) * $past(b_x, 2)));

endmodule

// File: rtl/avg_mac.sv
module avg_mac #(
    parameter int PW = 57,  // product width
    parameter int AW = 62,  // accumulator width
    parameter int OW = 41,  // output width
    parameter int SH = 18   // fraction bits dropped on output
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic                 in_head,
    input  logic                 in_endr,
    input  logic signed [PW-1:0] prod,
    output logic [OW-1:0]        f_val,
    output logic                 row_done
);

    logic signed [AW-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            row_done <= 1'b0;
        end else begin
            row_done <= in_vld && in_endr;
            if (in_vld) begin
                acc <= in_head ? AW'(prod) : acc + AW'(prod);
            end
        end
    end

    // Floor rescale with wrap: keep the bit slice above the dropped fraction
    assign f_val = acc[SH+OW-1:SH];

    p_acc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(acc));

endmodule

// File: rtl/affine_vec_gen.sv
module affine_vec_gen
    import avg_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int VLEN  = 11,
    parameter int XW    = 32,
    parameter int XF    = 20,
    parameter int FW    = 25,
    parameter int FF    = 20,
    parameter int OW    = 41,
    parameter int OF    = 22,
    parameter int SPLIT = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    host_sel,
    input  logic [XW-1:0] host_data,
    input  logic          host_wr,
    input  logic          start,
    output logic [3:0]    fwd_sel,
    output logic [OW-1:0] fwd_data,
    output logic          fwd_wr,
    output logic          solver_go,
    output logic          busy
);

    localparam int RW        = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CW        = (VLEN > 1) ? $clog2(VLEN) : 1;
    localparam int PW        = XW + FW;
    localparam int AW        = PW + CW + 1;
    localparam int SH        = XF + FF - OF;
    // Total run = ROWS*VLEN issue cycles + EXTRA.
    // After the last issue: combine(2) + accumulate(1) = PIPE, then TAIL.
    localparam int EXTRA     = 9;
    localparam int PIPE      = 3;
    localparam int TAIL      = EXTRA - PIPE;
    localparam int RUN_TOTAL = ROWS * VLEN + EXTRA;
    localparam int LCW       = $clog2(RUN_TOTAL + 2) + 1;
    localparam int WCW       = $clog2(ROWS + 2) + 1;

    gen_state_e state, state_nx;

    logic [RW-1:0]        row;
    logic [CW-1:0]        col;
    logic                 at_end;
    logic                 idle;
    tag_t                 tag_a, tag_b, tag_c;
    logic signed [FW-1:0] f_op;
    logic signed [XW-1:0] x_op;
    logic signed [PW-1:0] prod;
    logic [OW-1:0]        f_val;
    logic                 row_done;
    logic                 fin_d;
    logic [TAIL-1:0]      tail_q;

    assign idle      = (state == ST_IDLE);
    assign busy      = !idle;
    assign at_end    = (row == RW'(ROWS - 1)) && (col == CW'(VLEN - 1));
    assign solver_go = tail_q[TAIL-1];

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)             state_nx = ST_RUN;
            ST_RUN:   if (at_end)            state_nx = ST_DRAIN;
            ST_DRAIN: if (tail_q[TAIL-2])    state_nx = ST_IDLE;
            default:                         state_nx = ST_IDLE;
        endcase
    end

    // ---------------- element walk ----------------
    always_ff @(posedge clk) begin
        if (rst || idle) begin
            row <= '0;
            col <= '0;
        end else if (state == ST_RUN) begin
            if (col == CW'(VLEN - 1)) begin
                col <= '0;
                row <= row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    // ---------------- tag pipeline and trigger tail ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_a  <= '0;
            tag_b  <= '0;
            tag_c  <= '0;
            fin_d  <= 1'b0;
            tail_q <= '0;
        end else begin
            tag_a.vld  <= (state == ST_RUN);
            tag_a.head <= (col == '0);
            tag_a.endr <= (col == CW'(VLEN - 1));
            tag_a.endv <= (state == ST_RUN) && at_end;
            tag_b      <= tag_a;
            tag_c      <= tag_b;
            fin_d      <= tag_c.vld && tag_c.endv;
            tail_q     <= {tail_q[TAIL-2:0], fin_d};
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_sel  <= '0;
            fwd_data <= '0;
            fwd_wr   <= 1'b0;
        end else if (idle) begin
            fwd_sel  <= host_sel;
            fwd_data <= {{(OW-XW){1'b0}}, host_data};
            fwd_wr   <= host_wr;
        end else begin
            fwd_sel  <= SEL_FVEC;
            fwd_data <= f_val;
            fwd_wr   <= row_done;
        end
    end

    // ---------------- datapath ----------------
    avg_store #(
        .ROWS (ROWS),
        .VLEN (VLEN),
        .XW   (XW),
        .FW   (FW),
        .RW   (RW),
        .CW   (CW)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .idle      (idle),
        .host_sel  (host_sel),
        .host_data (host_data),
        .host_wr   (host_wr),
        .rd_row    (row),
        .rd_col    (col),
        .f_op      (f_op),
        .x_op      (x_op)
    );

    avg_splitmul #(
        .AW (XW),
        .BW (FW),
        .LO (SPLIT)
    ) u_mul (
        .clk (clk),
        .rst (rst),
        .a   (x_op),
        .b   (f_op),
        .p   (prod)
    );

    avg_mac #(
        .PW (PW),
        .AW (AW),
        .OW (OW),
        .SH (SH)
    ) u_mac (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (tag_c.vld),
        .in_head  (tag_c.head),
        .in_endr  (tag_c.endr),
        .prod     (prod),
        .f_val    (f_val),
        .row_done (row_done)
    );

    // ---------------- checker state ----------------
    logic [LCW-1:0] lat_q;
    logic [WCW-1:0] wcnt;
    logic           past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q   <= '0;
            wcnt    <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (idle) begin
                lat_q <= '0;
                wcnt  <= '0;
            end else begin
                lat_q <= lat_q + 1'b1;
                wcnt  <= wcnt + WCW'(row_done);
            end
        end
    end

    p_trig_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        solver_go |=> !solver_go);

    p_trig_idle_r7: assert property (@(posedge clk) disable iff (rst)
        solver_go |-> (!busy && $past(busy)));

    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        solver_go |-> (int'(lat_q) == RUN_TOTAL));

    p_fmode_r6: assert property (@(posedge clk) disable iff (rst)
        (fwd_wr && busy) |-> (fwd_sel == SEL_FVEC));

    p_wcount_r6: assert property (@(posedge clk) disable iff (rst)
        solver_go |-> (int'(wcnt) == ROWS));

    p_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(state) == ST_IDLE) |->
            (fwd_wr == $past(host_wr) && fwd_sel == $past(host_sel) &&
             fwd_data == {{(OW-XW){1'b0}}, $past(host_data)}));

endmodule

// File: tb/sim_affine_vec_gen.sv
module sim_affine_vec_gen;

    localparam int NR    = 8;
    localparam int NV    = 11;
    localparam int TOTAL = NR * NV + 9;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  host_sel;
    logic [31:0] host_data;
    logic        host_wr;
    logic        start;
    logic [3:0]  fwd_sel;
    logic [40:0] fwd_data;
    logic        fwd_wr;
    logic        solver_go;
    logic        busy;

    int checks = 0;
    int errors = 0;

    logic signed [24:0] fm [NR*NV];
    logic signed [31:0] xm [NV];
    logic [40:0]        expv [NR];

    always #5 clk = ~clk;

    affine_vec_gen u0 (
        .clk       (clk),
        .rst       (rst),
        .host_sel  (host_sel),
        .host_data (host_data),
        .host_wr   (host_wr),
        .start     (start),
        .fwd_sel   (fwd_sel),
        .fwd_data  (fwd_data),
        .fwd_wr    (fwd_wr),
        .solver_go (solver_go),
        .busy      (busy)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compute_exp();
        for (int i = 0; i < NR; i++) begin
            logic signed [63:0] s;
            logic signed [63:0] t;
            s = 0;
            for (int j = 0; j < NV; j++) begin
                s = s + longint'(fm[i*NV+j]) * longint'(xm[j]);
            end
            t = s >>> 18;
            expv[i] = t[40:0];
        end
    endtask

    task automatic quiet();
        @(negedge clk);
        host_sel  = 4'd0;
        host_wr   = 1'b0;
        host_data = 32'd0;
    endtask

    // R3: row-major matrix fill, preceded by junk that must be discarded
    task automatic load_mat(input int junk);
        for (int k = 0; k < junk; k++) begin
            @(negedge clk);
            host_sel = 4'd1; host_wr = 1'b1; host_data = $urandom;
        end
        quiet();
        for (int k = 0; k < NR*NV; k++) begin
            @(negedge clk);
            host_sel  = 4'd1;
            host_wr   = 1'b1;
            host_data = {7'($urandom), 25'(fm[k])};
        end
        quiet();
    endtask

    // R4: vector fill, preceded by junk that must be discarded
    task automatic load_vec(input int junk);
        for (int k = 0; k < junk; k++) begin
            @(negedge clk);
            host_sel = 4'd2; host_wr = 1'b1; host_data = $urandom;
        end
        quiet();
        for (int j = 0; j < NV; j++) begin
            @(negedge clk);
            host_sel  = 4'd2;
            host_wr   = 1'b1;
            host_data = xm[j];
        end
        quiet();
    endtask

    task automatic run(input bit disturb, input string tag);
        compute_exp();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);          // start accepted at the edge just passed
        start = 1'b0;
        for (int k = 1; k <= TOTAL + 3; k++) begin
            bit wexp;
            int ri;
            @(negedge clk);
            ri   = (k - 15) / NV;
            wexp = (k >= 15) && (((k - 15) % NV) == 0) && (ri < NR);
            check(fwd_wr == wexp, {"R6 R9 write slot ", tag}, 64'(fwd_wr), 64'(wexp));
            if (wexp) begin
                check(fwd_sel == 4'd3, {"R6 selector ", tag}, 64'(fwd_sel), 64'd3);
                check(fwd_data == expv[ri], {"R5 R3 R4 row value ", tag},
                      64'(fwd_data), 64'(expv[ri]));
            end
            check(solver_go == (k == TOTAL), {"R7 R8 trigger ", tag},
                  64'(solver_go), 64'(k == TOTAL));
            check(busy == (k < TOTAL), {"R7 R8 busy ", tag}, 64'(busy), 64'(k < TOTAL));
            if (disturb) begin
                if (k == 20) begin
                    start = 1'b1; host_sel = 4'd1; host_wr = 1'b1; host_data = $urandom;
                end else if (k == 22) begin
                    host_sel = 4'd2; host_data = $urandom;
                end else if (k == 25) begin
                    start = 1'b0; host_sel = 4'd0; host_wr = 1'b0;
                end else if (k == 60) begin
                    start = 1'b1;
                end else if (k == 61) begin
                    start = 1'b0;
                end
            end
        end
    endtask

    task automatic pass_case(input logic [3:0] s, input logic [31:0] d, input logic w);
        @(negedge clk);
        host_sel = s; host_data = d; host_wr = w;
        @(negedge clk);
        check(fwd_sel == s, "R2 selector", 64'(fwd_sel), 64'(s));
        check(fwd_data == {9'd0, d}, "R2 data", 64'(fwd_data), 64'(d));
        check(fwd_wr == w, "R2 strobe", 64'(fwd_wr), 64'(w));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; host_sel = 4'd0; host_wr = 1'b0; host_data = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
        check(fwd_wr == 1'b0, "R1 strobe", 64'(fwd_wr), 64'd0);
        check(solver_go == 1'b0, "R1 trigger", 64'(solver_go), 64'd0);
        check(fwd_data == 41'd0, "R1 data", 64'(fwd_data), 64'd0);
        check(fwd_sel == 4'd0, "R1 selector", 64'(fwd_sel), 64'd0);
        rst = 1'b0;

        // R2: idle forwarding
        pass_case(4'd0, 32'hDEAD_BEEF, 1'b1);
        pass_case(4'd3, 32'hFFFF_FFFF, 1'b1);
        pass_case(4'd5, 32'h1234_5678, 1'b0);
        pass_case(4'd15, 32'h8000_0001, 1'b1);
        pass_case(4'd1, 32'h0F0F_0F0F, 1'b0);
        quiet();

        // Pattern 1: random operands, constant one in the last element
        for (int k = 0; k < NR*NV; k++) fm[k] = 25'($urandom);
        for (int j = 0; j < NV; j++) xm[j] = $urandom;
        xm[NV-1] = 32'sd1 <<< 20;
        load_mat(5);
        load_vec(3);
        run(1'b0, "random");

        // Pattern 2 (R10): both operands at the negative limit, result wraps
        for (int k = 0; k < NR*NV; k++) fm[k] = 25'h100_0000;
        for (int j = 0; j < NV; j++) xm[j] = 32'h8000_0000;
        load_mat(0);
        load_vec(0);
        run(1'b0, "R10 negative limits");

        // Pattern 3 (R10): alternating positive and negative limits
        for (int k = 0; k < NR*NV; k++) fm[k] = (k % 2 == 0) ? 25'h0FF_FFFF : 25'h100_0000;
        for (int j = 0; j < NV; j++) xm[j] = (j % 3 == 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
        load_mat(2);
        load_vec(7);
        run(1'b0, "R10 mixed limits");

        // Pattern 4: small signed values to exercise floor rounding
        for (int k = 0; k < NR*NV; k++) fm[k] = 25'($signed(5'($urandom)));
        for (int j = 0; j < NV; j++) xm[j] = 32'($signed(9'($urandom)));
        load_mat(1);
        load_vec(1);
        run(1'b0, "R5 floor");

        // R8 R9: start and host writes during a run, then rerun unchanged data
        for (int k = 0; k < NR*NV; k++) fm[k] = 25'($urandom);
        for (int j = 0; j < NV; j++) xm[j] = $urandom;
        load_mat(0);
        load_vec(0);
        run(1'b1, "R8 R9 disturbed");
        run(1'b0, "R9 rerun");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule